// File: doc/BRIEF.md
# Quasi-Bidirectional Byte Port

This block is an 8-bit I/O port mapped into a processor's address space. It has no register that sets the direction of each pin. The value written into the output latch sets the direction. A latch bit of 0 drives its pin low. A latch bit of 1 turns the driver off, and the pin floats high through a weak pull-up unless something outside pulls it down. Software therefore makes a bit an input by writing 1 to it and reading the pin back. It makes a bit an output by writing the level it wants to see on the pin.

A read at the port address always returns the pin levels, never the latch. The pin levels first pass through a multi-flop synchroniser. Stores to the port address update the latch on the next clock edge. All other addresses leave the port unchanged and read as zero.

Top module: `quasi_port`

## Requirements
- R1: A synchronous active-high reset sets every latch bit to 1. After the first edge with reset high, `pad_oe` is 0x00, `pad_out` is 0xFF and `bus_rdata` is 0x00.
- R2: When `bus_we` is 1 and `bus_addr` equals PORT_ADDR (default 0x83) at a rising edge, the latch takes `bus_wdata` at that edge.
- R3: A write strobe at any other address leaves the latch, `pad_out` and `pad_oe` unchanged.
- R4: For every bit, a latch value of 0 gives `pad_oe`=1 and `pad_out`=0. A latch value of 1 gives `pad_oe`=0 and `pad_out`=1, which means the pin is released to the pull-up.
- R5: With `bus_addr` equal to PORT_ADDR at edge k, `bus_rdata` after edge k equals the `pad_in` value sampled at edge k-2. This latency comes from a two-stage synchroniser followed by one read register.
- R6: With `bus_addr` not equal to PORT_ADDR at an edge, `bus_rdata` after that edge is 0x00.
- R7: A read returns the pin levels, not the latch. With the latch at 0x00 and the pins at 0xA5, the read gives 0xA5.
- R8: With the pins wired as (external level AND NOT `pad_oe`), bits written 1 read back the external level, and bits written 0 read back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_oe | output | DATA_W | Pad driver enable, 1 = drive low |
| pad_out | output | DATA_W | Pad output value (the latch) |
| pad_in | input | DATA_W | Pad input level |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that a decoded store lands in the latch and that other stores leave it unchanged;
- that no bit is both driven and high;
- that reads at other addresses give zero;
- the exact read-back latency from the pins.

Only the bench scenarios can show the intent of the port: a released bit really acts as an input when an external source pulls the pin down, and a read gives the pins rather than the latch when the two differ.

// File: rtl/qp_pkg.sv
package qp_pkg;
  parameter int QP_DATA_W      = 8;
  parameter int QP_ADDR_W      = 8;
  parameter int QP_SYNC_STAGES = 2;
  parameter logic [QP_ADDR_W-1:0] QP_PORT_ADDR = 8'h83;
endpackage

// File: rtl/qp_decode.sv
module qp_decode #(
  parameter int ADDR_W = qp_pkg::QP_ADDR_W,
  parameter logic [ADDR_W-1:0] PORT_ADDR = qp_pkg::QP_PORT_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output logic              wr_hit
);
  always_comb begin
    hit    = (addr == PORT_ADDR);
    wr_hit = hit & we;
  end
endmodule

// File: rtl/qp_latch.sv
module qp_latch #(
  parameter int DATA_W = qp_pkg::QP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);
  // Each bit: 0 drives the pin low, 1 releases it to the pull-up.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[b] <= 1'b1;
        pad_oe[b]  <= 1'b0;
      end else if (wr_hit) begin
        pad_out[b] <= wdata[b];
        pad_oe[b]  <= ~wdata[b];
      end
    end
  end
endmodule

// File: rtl/qp_sync.sv
module qp_sync #(
  parameter int DATA_W = qp_pkg::QP_DATA_W,
  parameter int STAGES = qp_pkg::QP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qp_readback.sv
module qp_readback #(
  parameter int DATA_W = qp_pkg::QP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] pins_sync,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (hit) rdata <= pins_sync;
    else          rdata <= '0;
  end
endmodule

// File: rtl/quasi_port.sv
module quasi_port #(
  parameter int DATA_W      = qp_pkg::QP_DATA_W,
  parameter int ADDR_W      = qp_pkg::QP_ADDR_W,
  parameter logic [ADDR_W-1:0] PORT_ADDR = qp_pkg::QP_PORT_ADDR,
  parameter int SYNC_STAGES = qp_pkg::QP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pad_oe,
  output logic [DATA_W-1:0] pad_out,
  input  logic [DATA_W-1:0] pad_in
);
  logic              hit;
  logic              wr_hit;
  logic [DATA_W-1:0] pins_sync;

  qp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .we(bus_we), .hit(hit), .wr_hit(wr_hit)
  );

  qp_latch #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(bus_wdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  qp_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pins_sync)
  );

  qp_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .hit(hit), .pins_sync(pins_sync), .rdata(bus_rdata)
  );
endmodule

// File: rtl/qp_chk.sv
module qp_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h83,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] pad_oe,
  input logic [DATA_W-1:0] pad_out,
  input logic [DATA_W-1:0] pad_in
);
  logic [2:0] since_rst = '0;
  logic       seen_rst  = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      seen_rst  <= 1'b1;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '1 && bus_rdata == '0));

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == PORT_ADDR) |=> (pad_out == $past(bus_wdata)));

  // R3
  wr_ignore_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !(bus_we && bus_addr == PORT_ADDR) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R4
  no_drive_high_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (pad_oe & pad_out) == '0);

  // R6
  rd_other_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != PORT_ADDR) |=> (bus_rdata == '0));

  if (SYNC_STAGES == 2) begin : g_lat
    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst || since_rst < 3'd4)
      ($past(bus_addr) == PORT_ADDR) |-> (bus_rdata == $past(pad_in, 3)));
  end
endmodule

bind quasi_port qp_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_in(pad_in)
);

// File: tb/sim_quasi_port.sv
module sim_quasi_port;
  localparam int CLK_P  = 10;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam logic [7:0] PA = 8'h83;
  localparam int WDOG   = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, pad_oe, pad_out, pad_in;
  logic [DW-1:0] ext = 8'hFF;
  logic [DW-1:0] drv = 8'hFF;
  logic          wired = 1'b0;

  assign pad_in = wired ? (ext & ~pad_oe) : drv;

  quasi_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_in(pad_in)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit started = 1'b0;
  bit done    = 1'b0;
  string req  = "R1";

  // behavioural reference
  int        m_latch = 255;
  int        m_rd    = 0;
  int        pipe[$];

  always @(posedge clk) begin
    int front;
    cycles++;
    if (rst) begin
      m_latch = 255;
      m_rd    = 0;
      pipe    = {255, 255};
    end else begin
      front = pipe.pop_front();
      m_rd  = (bus_addr == PA) ? front : 0;
      pipe.push_back(int'(pad_in));
      if (bus_we && bus_addr == PA) m_latch = int'(bus_wdata);
    end
    started = 1'b1;
  end

  task automatic check(string r, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", r, what, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R4", "pad_out", int'(pad_out), m_latch);
      check("R4", "pad_oe", int'(pad_oe), (~m_latch) & 255);
      check(req, "bus_rdata", int'(bus_rdata), m_rd);
    end
  end

  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_we = we; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(PA, 1'b0, 8'h00);
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset pad_oe", int'(pad_oe), 0);
    check("R1", "reset pad_out", int'(pad_out), 255);
    check("R1", "reset rdata", int'(bus_rdata), 0);
    #1 rst = 1'b0;

    // R2/R4: store to the port drives bits low
    req = "R2";
    step(PA, 1'b1, 8'h55);
    step(PA, 1'b0, 8'h00);
    @(negedge clk);
    check("R2", "latch after store", int'(pad_out), 8'h55);
    check("R4", "oe after store", int'(pad_oe), 8'hAA);

    // R3: store elsewhere ignored
    req = "R3";
    step(8'h82, 1'b1, 8'h00);
    step(8'h84, 1'b1, 8'hF0);
    step(8'h03, 1'b1, 8'h0F);
    step(PA, 1'b0, 8'h00);
    @(negedge clk);
    check("R3", "latch after foreign stores", int'(pad_out), 8'h55);

    // R5: pin pattern read with latency
    req = "R5";
    step(PA, 1'b1, 8'hFF);
    drv = 8'h3C; idle(4);
    drv = 8'hC3; idle(1);
    drv = 8'h00; idle(1);
    drv = 8'h81; idle(4);
    check("R5", "settled read", int'(bus_rdata), 8'h81);

    // R6: other addresses read zero
    req = "R6";
    step(8'h80, 1'b0, 8'h00);
    step(8'h00, 1'b0, 8'h00);
    @(negedge clk);
    check("R6", "foreign read", int'(bus_rdata), 0);

    // R7: read shows pins, not latch
    req = "R7";
    step(PA, 1'b1, 8'h00);
    drv = 8'hA5; idle(4);
    check("R7", "pins vs latch", int'(bus_rdata), 8'hA5);

    // R8: wired pins, released bits act as inputs
    req = "R8";
    wired = 1'b1;
    ext = 8'hFF;
    step(PA, 1'b1, 8'hF0);
    idle(5);
    check("R8", "released high", int'(bus_rdata), 8'hF0);
    ext = 8'h5A; idle(4);
    check("R8", "external pull", int'(bus_rdata), 8'h50);
    step(PA, 1'b1, 8'hFF); idle(5);
    check("R8", "all input", int'(bus_rdata), 8'h5A);

    // R1 again: reset mid-run
    req = "R1";
    @(negedge clk); #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "re-reset pad_out", int'(pad_out), 255);
    #1 rst = 1'b0;
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WDOG);
    if (!done) begin
      done = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule